// File: doc/BRIEF.md
# Whole-Pixel Memory Word Packer

This block stores a stream of fixed-width pixels or samples in memory words that are wider than one pixel, and recovers the pixel stream from those words on read-back. A pixel is never split between two words. Each word carries the largest whole number of pixels that fits, which is the word width divided by the pixel width, rounded down. Any bits left over at the top of the word stay at zero and are wasted. For example, a 24-bit pixel in a 32-bit word fits once and wastes a quarter of the bits. The same pixel in a 256-bit word fits ten times and wastes 6.25%. A 10-bit sample in a 16-bit word fits once and loses 6 bits, while 8-bit samples pack two to a 16-bit word.

The write side has two parts. Pixels enter on a valid/ready stream with an end-of-line marker, and packed words leave with a count of the slots they fill. The read side takes words with their count and returns the pixels in their original order on a valid/ready stream. Both sides obey backpressure. The pixel width and the word width are parameters. A pixel width larger than the word width is refused at elaboration.

Top module: `pxw_word_packer`

## Requirements
- R1: The number of slots per word is floor(WORD_W / PIX_W), with 3 slots for the default 10-bit pixel and 32-bit word. A pixel width above the word width, or below 1, stops elaboration with an error.
- R2: Slot k of a packed word occupies bits [k*PIX_W +: PIX_W]. The first pixel of a word goes to slot 0 (the least significant bits), and each following pixel goes to the next higher slot.
- R3: Every bit of a packed word above its last filled slot is zero. This covers the unfilled slots of a partial word and the leftover bits above the top slot.
- R4: Once SLOTS pixels have been accepted without an end-of-line, the packer offers the word with a count of SLOTS and its end-of-line flag at 0.
- R5: A pixel accepted with end-of-line set closes the word early. The word is offered with a count equal to the number of pixels it holds (1 to SLOTS-1 for a partial word), and its end-of-line flag is at 1.
- R6: If the end-of-line pixel is also the one that fills the last slot, the packer emits exactly one word, with a count of SLOTS and the end-of-line flag at 1. No empty word follows it.
- R7: While a packed word is offered and the output is not ready, the word, its count and its flag stay unchanged. The pixel input is held off (ready low) once no space is left, and no pixel is lost or duplicated.
- R8: The unpacker returns the slots of each word in order, from slot 0 to count-1. It skips the slots at count and above, and it accepts only counts from 1 to SLOTS.
- R9: The unpacker's pixel end-of-line output is 1 only on the last valid pixel of a word whose end-of-line flag is set. It is 0 on every other pixel.
- R10: While an unpacked pixel is offered and not taken, the pixel and its end-of-line output stay stable, and no later pixel is skipped.
- R11: While reset is held and after it is released, neither output stream is valid, and both input streams show ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_in_valid | input | 1 | Pixel offered to the packer |
| pk_in_ready | output | 1 | Packer can take a pixel |
| pk_in_pix | input | PIX_W | Pixel value |
| pk_in_eol | input | 1 | Pixel ends a line; flushes the word |
| pk_out_valid | output | 1 | Packed word offered |
| pk_out_ready | input | 1 | Downstream takes the packed word |
| pk_out_word | output | WORD_W | Packed word |
| pk_out_cnt | output | CNT_W | Filled slots in the packed word |
| pk_out_eol | output | 1 | Packed word was closed by end-of-line |
| up_in_valid | input | 1 | Word offered to the unpacker |
| up_in_ready | output | 1 | Unpacker can take a word |
| up_in_word | input | WORD_W | Word to unpack |
| up_in_cnt | input | CNT_W | Valid slots in the word (1..SLOTS) |
| up_in_eol | input | 1 | Word ends a line |
| up_out_valid | output | 1 | Unpacked pixel offered |
| up_out_ready | input | 1 | Downstream takes the pixel |
| up_out_pix | output | PIX_W | Unpacked pixel |
| up_out_eol | output | 1 | Last pixel of a line |

## Verification
The unpacker's assertions assume that every offered word has a count between 1 and SLOTS. They also assume that a source keeps a word steady while it is stalled. The bench meets both assumptions by feeding the unpacker only from the packer's own output, so every count and every hold during a stall comes from a packed word. The pixel side is driven by a task that holds each pixel until the packer takes it. The readiness of the final output is toggled in a fixed pattern, which stalls both halves at different slot positions.

// File: rtl/pxw_pkg.sv
package pxw_pkg;

  // Whole pixels that fit in one word; remainder bits are wasted.
  function automatic int slots_of(input int word_w, input int pix_w);
    if (pix_w < 1) return 0;
    return word_w / pix_w;
  endfunction

  // Bits needed to hold a slot count from 0 up to slots.
  function automatic int cnt_bits(input int slots);
    return (slots < 1) ? 1 : $clog2(slots + 1);
  endfunction

  // Bits actually carrying pixel data in a word.
  function automatic int used_bits(input int word_w, input int pix_w);
    return slots_of(word_w, pix_w) * pix_w;
  endfunction

endpackage

// File: rtl/pxw_pack.sv
module pxw_pack #(
  parameter int PIX_W  = 10,
  parameter int WORD_W = 32,
  localparam int SLOTS = pxw_pkg::slots_of(WORD_W, PIX_W),
  localparam int CW    = pxw_pkg::cnt_bits(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [CW-1:0]     out_cnt,
  output logic              out_eol
);
  localparam int USED = pxw_pkg::used_bits(WORD_W, PIX_W);

  logic [WORD_W-1:0] acc_q, acc_next;
  logic [CW-1:0]     fill_q, base_fill, new_fill;
  logic              hold_q, weol_q;

  // Named internal events, observed by the assertions below.
  logic pk_accept, pk_emit, pk_close;

  assign pk_emit   = hold_q && out_ready;
  assign in_ready  = !hold_q || out_ready;
  assign pk_accept = in_valid && in_ready;
  assign base_fill = pk_emit ? '0 : fill_q;
  assign new_fill  = base_fill + 1'b1;
  assign pk_close  = pk_accept && ((new_fill == CW'(SLOTS)) || in_eol);

  always_comb begin
    acc_next = pk_emit ? '0 : acc_q;
    for (int s = 0; s < SLOTS; s++) begin
      if (base_fill == CW'(s)) acc_next[s*PIX_W +: PIX_W] = in_pix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
      hold_q <= 1'b0;
      weol_q <= 1'b0;
    end else if (pk_accept) begin
      acc_q  <= acc_next;
      fill_q <= new_fill;
      hold_q <= pk_close;
      weol_q <= pk_close && in_eol;
    end else if (pk_emit) begin
      acc_q  <= '0;
      fill_q <= '0;
      hold_q <= 1'b0;
      weol_q <= 1'b0;
    end
  end

  assign out_valid = hold_q;
  assign out_word  = acc_q;
  assign out_cnt   = fill_q;
  assign out_eol   = weol_q;

  AST_PK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cnt != '0) && (out_cnt <= CW'(SLOTS))); // R1

  AST_PK_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_cnt) && $stable(out_eol)); // R7

  AST_PK_EOL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    pk_accept && in_eol |=> out_valid && out_eol); // R5

  AST_PK_FULL_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pk_accept && (base_fill == CW'(SLOTS-1)) |=> out_valid && (out_cnt == CW'(SLOTS))); // R4

  AST_PK_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    pk_accept && (base_fill == '0) |=> acc_q[PIX_W-1:0] == $past(in_pix)); // R2

  generate
    if (USED < WORD_W) begin : g_pad
      AST_PK_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_word[WORD_W-1:USED] == '0); // R3
    end
  endgenerate

endmodule

// File: rtl/pxw_unpack.sv
module pxw_unpack #(
  parameter int PIX_W  = 10,
  parameter int WORD_W = 32,
  localparam int SLOTS = pxw_pkg::slots_of(WORD_W, PIX_W),
  localparam int CW    = pxw_pkg::cnt_bits(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [CW-1:0]     in_cnt,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix,
  output logic              out_eol
);
  logic [WORD_W-1:0] word_q;
  logic [CW-1:0]     cnt_q, idx_q, idx_inc;
  logic              weol_q, busy_q;

  // Named internal events, observed by the assertions below.
  logic up_pop, up_last, up_load;

  assign idx_inc  = idx_q + 1'b1;
  assign up_last  = (idx_inc == cnt_q);
  assign up_pop   = busy_q && out_ready;
  assign in_ready = !busy_q || (up_pop && up_last);
  assign up_load  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      weol_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (up_load) begin
      word_q <= in_word;
      cnt_q  <= in_cnt;
      weol_q <= in_eol;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (up_pop) begin
      if (up_last) busy_q <= 1'b0;
      else         idx_q  <= idx_inc;
    end
  end

  always_comb begin
    out_pix = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (idx_q == CW'(s)) out_pix = word_q[s*PIX_W +: PIX_W];
    end
  end

  assign out_valid = busy_q;
  assign out_eol   = busy_q && weol_q && up_last;

  AST_UP_CNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_cnt != '0) && (in_cnt <= CW'(SLOTS))); // R8

  AST_UP_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> idx_q < cnt_q); // R8

  AST_UP_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    up_load |=> out_valid && (out_pix == $past(in_word[PIX_W-1:0]))); // R8

  AST_UP_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    up_pop && up_last && !in_valid |=> !out_valid); // R8

  AST_UP_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_eol)); // R10

endmodule

// File: rtl/pxw_word_packer.sv
module pxw_word_packer #(
  parameter int PIX_W  = 10,
  parameter int WORD_W = 32,
  localparam int SLOTS = pxw_pkg::slots_of(WORD_W, PIX_W),
  localparam int CNT_W = pxw_pkg::cnt_bits(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pk_in_valid,
  output logic              pk_in_ready,
  input  logic [PIX_W-1:0]  pk_in_pix,
  input  logic              pk_in_eol,
  output logic              pk_out_valid,
  input  logic              pk_out_ready,
  output logic [WORD_W-1:0] pk_out_word,
  output logic [CNT_W-1:0]  pk_out_cnt,
  output logic              pk_out_eol,
  input  logic              up_in_valid,
  output logic              up_in_ready,
  input  logic [WORD_W-1:0] up_in_word,
  input  logic [CNT_W-1:0]  up_in_cnt,
  input  logic              up_in_eol,
  output logic              up_out_valid,
  input  logic              up_out_ready,
  output logic [PIX_W-1:0]  up_out_pix,
  output logic              up_out_eol
);

  // R1: a pixel must fit whole in one word.
  generate
    if (PIX_W < 1 || PIX_W > WORD_W) begin : g_bad_cfg
      $error("pxw_word_packer: pixel width must be 1..WORD_W");
    end
  endgenerate

  pxw_pack #(.PIX_W(PIX_W), .WORD_W(WORD_W)) pack_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pk_in_valid),
    .in_ready  (pk_in_ready),
    .in_pix    (pk_in_pix),
    .in_eol    (pk_in_eol),
    .out_valid (pk_out_valid),
    .out_ready (pk_out_ready),
    .out_word  (pk_out_word),
    .out_cnt   (pk_out_cnt),
    .out_eol   (pk_out_eol)
  );

  pxw_unpack #(.PIX_W(PIX_W), .WORD_W(WORD_W)) unpack_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (up_in_valid),
    .in_ready  (up_in_ready),
    .in_word   (up_in_word),
    .in_cnt    (up_in_cnt),
    .in_eol    (up_in_eol),
    .out_valid (up_out_valid),
    .out_ready (up_out_ready),
    .out_pix   (up_out_pix),
    .out_eol   (up_out_eol)
  );

endmodule

// File: tb/pxw_word_packer_tb.sv
module pxw_word_packer_tb_top;
  localparam int PIX_W  = 10;
  localparam int WORD_W = 32;
  localparam int NSLOT  = WORD_W / PIX_W;   // restated: floor division
  localparam int CNT_W  = 2;
  localparam int DEPTH  = 64;

  // {eol, pixel}
  localparam logic [PIX_W:0] VEC [15] = '{
    {1'b0, 10'h3FF}, {1'b0, 10'h155}, {1'b0, 10'h2AA},
    {1'b1, 10'h123},
    {1'b0, 10'h0F0}, {1'b1, 10'h30F},
    {1'b0, 10'h001}, {1'b0, 10'h200}, {1'b1, 10'h3FF},
    {1'b0, 10'h07E}, {1'b0, 10'h181}, {1'b0, 10'h2C3},
    {1'b0, 10'h011}, {1'b1, 10'h3C0},
    {1'b1, 10'h0AB}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              pk_in_valid = 1'b0, pk_in_eol = 1'b0, up_out_ready = 1'b1;
  logic [PIX_W-1:0]  pk_in_pix = '0;
  logic              pk_in_ready, pk_out_valid, pk_out_ready, pk_out_eol;
  logic [WORD_W-1:0] pk_out_word;
  logic [CNT_W-1:0]  pk_out_cnt;
  logic              up_in_ready, up_out_valid, up_out_eol;
  logic [PIX_W-1:0]  up_out_pix;

  pxw_word_packer #(.PIX_W(PIX_W), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pk_in_valid(pk_in_valid), .pk_in_ready(pk_in_ready), .pk_in_pix(pk_in_pix), .pk_in_eol(pk_in_eol),
    .pk_out_valid(pk_out_valid), .pk_out_ready(pk_out_ready), .pk_out_word(pk_out_word),
    .pk_out_cnt(pk_out_cnt), .pk_out_eol(pk_out_eol),
    .up_in_valid(pk_out_valid), .up_in_ready(up_in_ready), .up_in_word(pk_out_word),
    .up_in_cnt(pk_out_cnt), .up_in_eol(pk_out_eol),
    .up_out_valid(up_out_valid), .up_out_ready(up_out_ready), .up_out_pix(up_out_pix), .up_out_eol(up_out_eol)
  );
  assign pk_out_ready = up_in_ready;

  int checks = 0, errors = 0, cyc = 0;

  // Expected streams built from the requirements as pixels are accepted.
  logic [WORD_W-1:0] w_exp [DEPTH];
  int                w_cnt [DEPTH];
  logic              w_eol [DEPTH];
  logic [PIX_W-1:0]  p_exp [DEPTH];
  logic              p_eol [DEPTH];
  int wwr = 0, wrd = 0, pwr = 0, prd = 0;
  logic [WORD_W-1:0] m_acc = '0;
  int m_fill = 0;
  bit stall_run = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic model_push(input logic [PIX_W-1:0] pix, input logic eol);
    p_exp[pwr] = pix; p_eol[pwr] = eol; pwr++;
    m_acc[m_fill*PIX_W +: PIX_W] = pix;   // R2 slot placement
    m_fill++;
    if (m_fill == NSLOT || eol) begin
      w_exp[wwr] = m_acc; w_cnt[wwr] = m_fill; w_eol[wwr] = eol; wwr++;
      m_acc = '0; m_fill = 0;
    end
  endtask

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic send(input logic [PIX_W-1:0] pix, input logic eol);
    pk_in_valid = 1'b1; pk_in_pix = pix; pk_in_eol = eol;
    forever begin
      @(negedge clk);
      if (pk_in_ready) break;
    end
    model_push(pix, eol);
    @(posedge clk); #1;
    pk_in_valid = 1'b0;
  endtask

  // Word monitor: handshake seen half a cycle before the edge that completes it.
  always @(negedge clk) begin
    if (rst_n && pk_out_valid && up_in_ready) begin
      if (wrd >= wwr) begin
        check(1'b0, "R7", "word with no pixel behind it", pk_out_word, '0);
      end else begin
        check(pk_out_word == w_exp[wrd], "R2/R3", "packed word data", pk_out_word, w_exp[wrd]);
        if (w_eol[wrd] && w_cnt[wrd] == NSLOT)
          check(pk_out_cnt == CNT_W'(w_cnt[wrd]) && pk_out_eol, "R6", "full word with eol cnt/eol",
                {pk_out_eol, 29'd0, pk_out_cnt}, {1'b1, 29'd0, CNT_W'(w_cnt[wrd])});
        else if (w_eol[wrd])
          check(pk_out_cnt == CNT_W'(w_cnt[wrd]) && pk_out_eol, "R5", "flushed word cnt/eol",
                {pk_out_eol, 29'd0, pk_out_cnt}, {1'b1, 29'd0, CNT_W'(w_cnt[wrd])});
        else
          check(pk_out_cnt == CNT_W'(NSLOT) && !pk_out_eol, "R1/R4", "full word cnt/eol",
                {pk_out_eol, 29'd0, pk_out_cnt}, {1'b0, 29'd0, CNT_W'(NSLOT)});
        wrd++;
      end
    end
  end

  // Pixel monitor.
  always @(negedge clk) begin
    if (rst_n && up_out_valid && up_out_ready) begin
      if (prd >= pwr) begin
        check(1'b0, "R8", "extra pixel", {22'd0, up_out_pix}, '0);
      end else begin
        check(up_out_pix == p_exp[prd], "R8", "unpacked pixel order", {22'd0, up_out_pix}, {22'd0, p_exp[prd]});
        check(up_out_eol == p_eol[prd], "R9", "pixel end-of-line", {31'd0, up_out_eol}, {31'd0, p_eol[prd]});
        prd++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL R7 watchdog: actual cycles=%0d expected below 20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic drain(input string req);
    for (int i = 0; i < 200; i++) begin
      if (wrd == wwr && prd == pwr) break;
      @(posedge clk);
    end
    #1;
    check(wrd == wwr, req, "all words delivered", wrd, wwr);
    check(prd == pwr, req, "all pixels delivered", prd, pwr);
  endtask

  logic [WORD_W-1:0] held_word;
  logic [PIX_W-1:0]  held_pix;

  initial begin
    // R11: reset state, during and after reset.
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!pk_out_valid && !up_out_valid, "R11", "valids in reset", {pk_out_valid, up_out_valid}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(!pk_out_valid && !up_out_valid, "R11", "valids after reset", {pk_out_valid, up_out_valid}, 0);
    check(pk_in_ready && up_in_ready, "R11", "readies after reset", {pk_in_ready, up_in_ready}, 2'b11);
    @(posedge clk); #1;

    // Pass 1: vector table, output always ready.
    for (int i = 0; i < 15; i++) send(VEC[i][PIX_W-1:0], VEC[i][PIX_W]);
    drain("R4/R8");

    // Pass 2: same table under a toggling output-ready pattern (R7, R10).
    stall_run = 1;
    fork
      begin
        for (int k = 0; stall_run; k++) begin
          @(posedge clk); #1;
          up_out_ready = (k % 3) != 0;
        end
        up_out_ready = 1'b1;
      end
      begin
        for (int i = 0; i < 15; i++) send(VEC[i][PIX_W-1:0], VEC[i][PIX_W]);
        stall_run = 0;
      end
    join
    drain("R7/R10");

    // Directed stall: output blocked, two full words pile up.
    @(posedge clk); #1 up_out_ready = 1'b0;
    for (int i = 0; i < 6; i++) send(10'(10'h050 + i * 10'h067), 1'b0);
    @(negedge clk);
    held_word = pk_out_word;
    held_pix  = up_out_pix;
    check(held_pix == 10'h050, "R10", "first slot offered while stalled", {22'd0, held_pix}, 32'h050);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!pk_in_ready, "R7", "input held off when full", {31'd0, pk_in_ready}, 0);
      check(pk_out_valid && pk_out_word == held_word, "R7", "stalled word stable", pk_out_word, held_word);
      check(up_out_valid && up_out_pix == held_pix, "R10", "stalled pixel stable", {22'd0, up_out_pix}, {22'd0, held_pix});
    end
    @(posedge clk); #1 up_out_ready = 1'b1;
    drain("R7");

    // Single-pixel line right after the stall: partial word of one.
    send(10'h2F1, 1'b1);
    drain("R5");

    summary();
    $finish;
  end

endmodule